// File: doc/BRIEF.md
# Serial Flash Status-Register Write Controller

This block is the slave-side command logic of a serial flash device that owns the write-enable latch and the protection fields of the status register. It watches the serial clock, chip-select, serial data input and write-protect pin. It samples data on rising serial-clock edges, so both idle-low (mode 0) and idle-high (mode 3) clocking work. It collects a one-byte opcode and an optional data byte. It acts on an instruction only when chip-select returns high.

Four instructions are handled: write-disable, write-enable, enable-write-status and write-status. The status register can only be rewritten by a write-status instruction that comes straight after an arming instruction. A lock-down bit works together with the write-protect pin to freeze the protection fields. The busy flag comes from an outside input, and a second input stands in for the start of an auto-increment program, which sets the auto-increment flag. The pins reach an internal clock domain through a parameterised synchroniser chain. The register contents are always visible on a parallel output.

Top module: `spi_sr_ctrl`

## Requirements
- R1: After reset, status_q reads 0x00 with busy_in low, and no arming is pending. Status bit layout: 0 busy, 1 write-enable latch, 2..5 protect field (bit 2 is its LSB), 6 auto-increment flag, 7 lock-down.
- R2: Status bit 0 follows busy_in with a one-clock delay, and no instruction changes it.
- R3: Opcode 0x06 sets bit 1 and arms a following write-status instruction.
- R4: Opcode 0x04 clears bits 1 and 6 and leaves bit 0 (busy) as it was.
- R5: Opcode 0x50 or 0x06, followed immediately by opcode 0x01 plus one data byte (both MSB first), loads data bits 2..5 and 7 into the same status bits. Data bits 0, 1 and 6 are ignored.
- R6: A write-status instruction that does not directly follow an arming instruction leaves the status register unchanged. Any instruction in between cancels the arming.
- R7: No instruction takes effect while chip-select is still low, even after all of its bits have been shifted in. It takes effect only after chip-select rises.
- R8: With write-protect low and bit 7 set, write-status changes nothing.
- R9: With write-protect low and bit 7 clear, one write-status may set bit 7 and rewrite the protect field together.
- R10: With write-protect high, write-status may clear bit 7.
- R11: A transfer of any length other than 8 bits (16 bits for write-status) is discarded and cancels a pending arming.
- R12: The serial output is never driven: spi_so_oe stays 0.
- R13: A pulse on aai_start sets bit 6.
- R14: Write-protect is judged by its level just before chip-select rises, not by its level while bits are being shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_si | input | 1 | Serial data in |
| spi_wp_n | input | 1 | Write-protect pin, active low |
| busy_in | input | 1 | Busy indication from the program engine |
| aai_start | input | 1 | Pulse when an auto-increment program starts |
| spi_so | output | 1 | Serial data out (unused value) |
| spi_so_oe | output | 1 | Output enable for spi_so, always 0 |
| status_q | output | 8 | Current status register |

## Verification
The checker watches these rules on every cycle:
- The busy bit mirrors its input.
- The lock-down and protect bits move only in the cycle after a command commits.
- These bits stay frozen when a commit arrives with write-protect low and lock-down set.
- The write-enable latch rises only on a commit, and the auto-increment flag rises only after its start pulse.

Some behaviours can only be shown by the bench's scenarios:
- Opcode decoding and the arming order.
- Rejection of transfers with the wrong bit count.
- Waiting for chip-select to rise before acting.
- Sampling write-protect at the end of the transfer.
- Both clock polarities.
These scenarios check the register value that each instruction sequence should produce.

// File: rtl/spi_sr_pkg.sv
package spi_sr_pkg;
  localparam logic [7:0] OP_WRDIS = 8'h04;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_ARM   = 8'h50;
  localparam logic [7:0] OP_WRSTS = 8'h01;

  localparam int SR_BUSY  = 0;
  localparam int SR_WEL   = 1;
  localparam int SR_PROT  = 2;
  localparam int PROT_W   = 4;
  localparam int SR_AUTO  = 6;
  localparam int SR_LOCK  = 7;
  localparam int SR_W     = 8;
endpackage

// File: rtl/spi_sr_sync.sv
module spi_sr_sync #(
  parameter int STAGES = 2,
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (STAGES == 0) begin : g_pass
      assign q = d;
    end else begin : g_chain
      logic [W-1:0] st [STAGES];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
        end else begin
          st[0] <= d;
          for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
        end
      end
      assign q = st[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/spi_sr_shifter.sv
module spi_sr_shifter #(
  parameter int CMD_BITS = 8,
  parameter int DATA_BITS = 8,
  localparam int WORD_W = CMD_BITS + DATA_BITS,
  localparam int CNT_MAX = WORD_W + 1,
  localparam int CNT_W = $clog2(CNT_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              si,
  input  logic              wp_n,
  output logic              done,
  output logic [WORD_W-1:0] word,
  output logic [CNT_W-1:0]  cnt,
  output logic              wp_n_end
);
  logic              sck_q, cs_q;
  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  bits;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q    <= 1'b0;
      cs_q     <= 1'b1;
      shreg    <= '0;
      bits     <= '0;
      done     <= 1'b0;
      word     <= '0;
      cnt      <= '0;
      wp_n_end <= 1'b1;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
      done  <= 1'b0;
      if (cs_n && !cs_q) begin
        done     <= 1'b1;
        word     <= shreg;
        cnt      <= bits;
        wp_n_end <= wp_n;
        bits     <= '0;
      end else if (!cs_n && sck && !sck_q) begin
        shreg <= {shreg[WORD_W-2:0], si};
        if (bits != CNT_W'(CNT_MAX)) bits <= bits + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_sr_exec.sv
module spi_sr_exec
  import spi_sr_pkg::*;
#(
  parameter int CMD_BITS = 8,
  parameter int DATA_BITS = 8,
  parameter logic [PROT_W-1:0] PROT_RST = '0,
  localparam int WORD_W = CMD_BITS + DATA_BITS,
  localparam int CNT_W = $clog2(WORD_W + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done,
  input  logic [WORD_W-1:0] word,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              wp_n_end,
  input  logic              busy_in,
  input  logic              aai_start,
  output logic [SR_W-1:0]   status
);
  logic              busy_q, wel, auto_f, lock, armed;
  logic [PROT_W-1:0] prot;
  logic              is_short, is_long, locked;
  logic [CMD_BITS-1:0]  op_s, op_l;
  logic [DATA_BITS-1:0] dat;

  always_comb begin
    is_short = (cnt == CNT_W'(CMD_BITS));
    is_long  = (cnt == CNT_W'(WORD_W));
    op_s     = word[CMD_BITS-1:0];
    op_l     = word[WORD_W-1:DATA_BITS];
    dat      = word[DATA_BITS-1:0];
    locked   = !wp_n_end && lock;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      wel    <= 1'b0;
      auto_f <= 1'b0;
      lock   <= 1'b0;
      armed  <= 1'b0;
      prot   <= PROT_RST;
    end else begin
      busy_q <= busy_in;
      if (aai_start) auto_f <= 1'b1;
      if (done) begin
        armed <= 1'b0;
        if (is_short && op_s == OP_WRDIS) begin
          wel    <= 1'b0;
          auto_f <= 1'b0;
        end else if (is_short && op_s == OP_WREN) begin
          wel   <= 1'b1;
          armed <= 1'b1;
        end else if (is_short && op_s == OP_ARM) begin
          armed <= 1'b1;
        end else if (is_long && op_l == OP_WRSTS && armed && !locked) begin
          prot <= dat[SR_PROT +: PROT_W];
          lock <= dat[SR_LOCK];
        end
      end
    end
  end

  always_comb begin
    status          = '0;
    status[SR_BUSY] = busy_q;
    status[SR_WEL]  = wel;
    status[SR_PROT +: PROT_W] = prot;
    status[SR_AUTO] = auto_f;
    status[SR_LOCK] = lock;
  end
endmodule

// File: rtl/spi_sr_ctrl.sv
module spi_sr_ctrl
  import spi_sr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter logic [PROT_W-1:0] PROT_RST = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            spi_sck,
  input  logic            spi_cs_n,
  input  logic            spi_si,
  input  logic            spi_wp_n,
  input  logic            busy_in,
  input  logic            aai_start,
  output logic            spi_so,
  output logic            spi_so_oe,
  output logic [SR_W-1:0] status_q
);
  localparam int CMD_BITS = 8;
  localparam int DATA_BITS = 8;
  localparam int WORD_W = CMD_BITS + DATA_BITS;
  localparam int CNT_W = $clog2(WORD_W + 2);

  logic [3:0]        pins_s;
  logic              cmd_done, cmd_wp_n;
  logic [WORD_W-1:0] cmd_word;
  logic [CNT_W-1:0]  cmd_cnt;

  spi_sr_sync #(.STAGES(SYNC_STAGES), .W(4), .RST_VAL(4'b0101)) u_sync (
    .clk(clk), .rst(rst),
    .d({spi_sck, spi_cs_n, spi_si, spi_wp_n}),
    .q(pins_s)
  );

  spi_sr_shifter #(.CMD_BITS(CMD_BITS), .DATA_BITS(DATA_BITS)) u_shift (
    .clk(clk), .rst(rst),
    .sck(pins_s[3]), .cs_n(pins_s[2]), .si(pins_s[1]), .wp_n(pins_s[0]),
    .done(cmd_done), .word(cmd_word), .cnt(cmd_cnt), .wp_n_end(cmd_wp_n)
  );

  spi_sr_exec #(.CMD_BITS(CMD_BITS), .DATA_BITS(DATA_BITS), .PROT_RST(PROT_RST)) u_exec (
    .clk(clk), .rst(rst),
    .done(cmd_done), .word(cmd_word), .cnt(cmd_cnt), .wp_n_end(cmd_wp_n),
    .busy_in(busy_in), .aai_start(aai_start),
    .status(status_q)
  );

  assign spi_so    = 1'b0;
  assign spi_so_oe = 1'b0;
endmodule

// File: rtl/spi_sr_ctrl_chk.sv
module spi_sr_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       cmd_done,
  input logic       cmd_wp_n,
  input logic       busy_in,
  input logic       aai_start,
  input logic [7:0] status_q
);
  p_busy_mirror_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> status_q[0] == $past(busy_in));

  p_commit_only_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(cmd_done) |-> (status_q[7] == $past(status_q[7]) && status_q[5:2] == $past(status_q[5:2])));

  p_lock_hold_r8: assert property (@(posedge clk) disable iff (rst)
    $past(cmd_done && !cmd_wp_n && status_q[7]) |->
      (status_q[7] == $past(status_q[7]) && status_q[5:2] == $past(status_q[5:2])));

  p_wel_on_commit_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(status_q[1]) |-> $past(cmd_done));

  p_auto_on_start_r13: assert property (@(posedge clk) disable iff (rst)
    $rose(status_q[6]) |-> $past(aai_start));
endmodule

bind spi_sr_ctrl spi_sr_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .cmd_done(cmd_done), .cmd_wp_n(cmd_wp_n),
  .busy_in(busy_in), .aai_start(aai_start), .status_q(status_q)
);

// File: tb/spi_sr_ctrl_tb.sv
module spi_sr_ctrl_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, wp_n = 1'b1, busy = 1'b0, aai = 1'b0;
  logic so, so_oe;
  logic [7:0] st;
  logic idle_hi = 1'b0;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  spi_sr_ctrl u_dut (
    .clk(clk), .rst(rst), .spi_sck(sck), .spi_cs_n(cs_n), .spi_si(si),
    .spi_wp_n(wp_n), .busy_in(busy), .aai_start(aai),
    .spi_so(so), .spi_so_oe(so_oe), .status_q(st)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic shift_bits(input logic [15:0] v, input int n);
    sck = idle_hi;
    tick(2);
    cs_n = 1'b0;
    tick(4);
    for (int i = 0; i < n; i++) begin
      si = v[n-1-i];
      sck = 1'b0;
      tick(4);
      sck = 1'b1;
      tick(4);
    end
    sck = idle_hi;
    tick(4);
  endtask

  task automatic end_cmd();
    cs_n = 1'b1;
    tick(12);
  endtask

  task automatic op8(input logic [7:0] op);
    shift_bits({8'h00, op}, 8);
    end_cmd();
  endtask

  task automatic wrsts(input logic [7:0] d);
    shift_bits({8'h01, d}, 16);
    end_cmd();
  endtask

  task automatic t_reset();
    check("R1 reset status", st, 8'h00);
    check("R12 so_oe at reset", {7'd0, so_oe}, 8'h00);
    wrsts(8'hBC);
    check("R1 no arming after reset", st, 8'h00);
  endtask

  task automatic t_busy();
    busy = 1'b1;
    tick(3);
    check("R2 busy mirrored", st, 8'h01);
    op8(8'h04);
    check("R4 write-disable keeps busy", st, 8'h01);
    busy = 1'b0;
    tick(3);
    check("R2 busy cleared", st, 8'h00);
  endtask

  task automatic t_wren_wrdis();
    op8(8'h06);
    check("R3 write-enable sets latch", st, 8'h02);
    aai = 1'b1; tick(1); aai = 1'b0; tick(2);
    check("R13 auto flag set", st, 8'h42);
    op8(8'h04);
    check("R4 write-disable clears latch and auto", st, 8'h00);
  endtask

  task automatic t_write_ok();
    idle_hi = 1'b1;
    op8(8'h50);
    wrsts(8'h7F);
    check("R5 arm 0x50 then write, mode 3", st, 8'h3C);
    idle_hi = 1'b0;
    op8(8'h06);
    wrsts(8'h14);
    check("R5 arm 0x06 then write", st, 8'h16);
    op8(8'h04);
  endtask

  task automatic t_unarmed();
    wrsts(8'h00);
    check("R6 write without arming", st, 8'h14);
    op8(8'h50);
    op8(8'h04);
    wrsts(8'h00);
    check("R6 instruction between cancels arming", st, 8'h14);
  endtask

  task automatic t_commit();
    shift_bits(16'h0006, 8);
    tick(10);
    check("R7 no effect with CS low", st, 8'h14);
    end_cmd();
    check("R7 effect after CS rise", st, 8'h16);
    op8(8'h04);
  endtask

  task automatic t_badcount();
    op8(8'h50);
    shift_bits(16'h0003, 9);
    end_cmd();
    wrsts(8'h00);
    check("R11 9-bit transfer cancels arming", st, 8'h14);
    shift_bits(16'h0003, 7);
    end_cmd();
    check("R11 7-bit write-enable discarded", st, 8'h14);
    op8(8'h50);
    shift_bits(16'h0100, 15);
    end_cmd();
    check("R11 short write-status discarded", st, 8'h14);
  endtask

  task automatic t_lock();
    op8(8'h50); wrsts(8'h88);
    check("R10 set lock with WP high", st, 8'h88);
    wp_n = 1'b0;
    op8(8'h50); wrsts(8'h00);
    check("R8 locked write ignored", st, 8'h88);
    wp_n = 1'b1;
    op8(8'h50); wrsts(8'h00);
    check("R10 clear lock with WP high", st, 8'h00);
    wp_n = 1'b0;
    op8(8'h50); wrsts(8'hA0);
    check("R9 set lock and protect with WP low", st, 8'hA0);
  endtask

  task automatic t_wp_end();
    op8(8'h50);
    shift_bits(16'h0100, 16);
    wp_n = 1'b1;
    tick(4);
    end_cmd();
    check("R14 WP raised before CS rise", st, 8'h00);
    op8(8'h50); wrsts(8'h80);
    op8(8'h50);
    shift_bits(16'h0100, 16);
    wp_n = 1'b0;
    tick(4);
    end_cmd();
    check("R14 WP dropped before CS rise", st, 8'h80);
    check("R12 so_oe stays low", {7'd0, so_oe}, 8'h00);
    wp_n = 1'b1;
  endtask

  initial begin
    tick(5);
    rst = 1'b0;
    tick(3);
    t_reset();
    t_busy();
    t_wren_wrdis();
    t_write_ok();
    t_unarmed();
    t_commit();
    t_badcount();
    t_lock();
    t_wp_end();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #1500000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule